// File: doc/BRIEF.md
# Three-Channel Compare General-Purpose Timer

This block is a 32-bit up-counting timer reached through a small word-addressed register bus. A count tick is formed from one of two external tick-enable inputs: a fast peripheral tick or a slow 32 kHz tick. The control register selects the input, and a 12-bit prescaler then divides it. On every count tick the counter value is compared against three compare registers. A match sets a status flag. Passing the top of the count range sets a rollover flag. A single level interrupt is raised while an enabled flag is pending and the timer is running.

Two counting modes exist. In free-run mode the counter runs through the whole range and wraps. In restart mode the first compare channel sets the period: the counter returns to zero after matching it, and any write to that channel also zeroes the count. A soft-reset bit in the control register returns most state to its reset values while keeping part of the control word. The capture registers only hold their reset value.

Top module: `cmp_timer`

## Requirements
- R1: Word indices 0 to 9 map, in order, to control, prescaler, status, interrupt enable, compare 1, compare 2, compare 3, capture 1, capture 2 and counter. Reads of any other index return zero, and writes to other indices have no effect. The counter and capture registers ignore writes.
- R2: After reset, the compare registers read 0xFFFFFFFF, all other registers read zero, and the interrupt is low.
- R3: Control bit positions are: bit 0 run, bit 1 zero-on-start, bit 3 wait enable, bit 5 stop enable, bits 8:6 source select, bit 9 free-run, bit 15 soft reset. A control write stores its value with bits 2, 4 and 10 to 15 forced to zero, so bit 15 always reads back 0.
- R4: A control write with bit 15 set clears status, prescaler, interrupt enable, counter and both capture registers, and sets all compare registers to all ones. It also clears control bits 0, 1, 3 and 5 of the written value and keeps its other bits.
- R5: Source codes 001 and 010 select the fast tick and code 100 selects the slow tick. Any other code gives no count. The counter advances once per (prescaler + 1) selected ticks.
- R6: While the run bit is clear the counter holds its value. A control write that sets run from 0 to 1 while also setting zero-on-start zeroes the counter.
- R7: On a count tick, a counter value equal to compare channel n (n = 1..3) sets status bit n-1. Status bits 3 and 4 are never set.
- R8: On a count tick at the all-ones value the counter wraps to zero and status bit 5 (rollover) is set.
- R9: In restart mode (free-run bit clear) a count tick at the compare 1 value returns the counter to zero, giving a period of compare 1 + 1 ticks.
- R10: In restart mode any write to compare 1 zeroes the counter.
- R11: A status write clears each flag whose written bit is 1 and leaves the others. A flag set by hardware in the same cycle stays set.
- R12: The interrupt output is high exactly when (status AND interrupt enable) is nonzero and the run bit is set.
- R13: The prescaler stores the low 12 bits of a write and interrupt enable stores the low 6 bits. Only those bits read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_fast_i | input | 1 | Peripheral clock tick enable |
| tick_slow_i | input | 1 | 32 kHz tick enable |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_idx_i | input | 4 | Word index of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of a read strobe |
| irq_o | output | 1 | Level interrupt |

## Verification
The checker watches several rules on every clock: counter hold while stopped, return to zero after a compare 1 match in restart mode, rollover flagging, write-one-to-clear status with set priority, the soft-reset effect, and interrupt silence while stopped. Other behaviour only shows up in the bench scenarios. This covers the register map and its masks, the source codes and the prescaler rates measured over windows of cycles, the restart period seen through counter reads, and full-range wrap on a narrow counter instance.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned NFLAG  = 6;
  localparam int unsigned NCMP   = 3;
  localparam int unsigned NCAP   = 2;
  localparam int unsigned FL_ROLL = 5;

  // register word indices
  localparam int unsigned IX_CTRL = 0;
  localparam int unsigned IX_PSC  = 1;
  localparam int unsigned IX_STAT = 2;
  localparam int unsigned IX_IEN  = 3;
  localparam int unsigned IX_CMP1 = 4;
  localparam int unsigned IX_CAP1 = 7;
  localparam int unsigned IX_CNT  = 9;

  // control bit positions
  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_ZERO  = 1;
  localparam int unsigned CB_SRC   = 6;
  localparam int unsigned CB_FREE  = 9;
  localparam int unsigned CB_SOFT  = 15;

  localparam logic [BUS_W-1:0] CTRL_FORCE0 = 32'h0000_7C14;
  localparam logic [BUS_W-1:0] CTRL_SELFCLR = 32'h0000_8000;
  localparam logic [BUS_W-1:0] CTRL_RSTCLR = 32'h0000_002B;

  typedef enum logic [1:0] {SRC_NONE, SRC_FAST, SRC_SLOW} src_t;

  function automatic src_t decode_src(input logic [2:0] code);
    src_t s;
    case (code)
      3'b001, 3'b010: s = SRC_FAST;
      3'b100:         s = SRC_SLOW;
      default:        s = SRC_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/cmt_rst_sync.sv
module cmt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/cmt_tick_sel.sv
module cmt_tick_sel import cmt_pkg::*; #(
  parameter int unsigned PSW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic [2:0]     src_i,
  input  logic           tick_fast_i,
  input  logic           tick_slow_i,
  input  logic [PSW-1:0] div_i,
  input  logic           clr_i,
  output logic           cnt_tick_o
);
  logic [PSW-1:0] ph_q, ph_d;
  logic           ph_en, src_tick, terminal;

  always_comb begin
    case (decode_src(src_i))
      SRC_FAST: src_tick = tick_fast_i;
      SRC_SLOW: src_tick = tick_slow_i;
      default:  src_tick = 1'b0;
    endcase
    // >= so that lowering the divider mid-phase cannot stall the count
    terminal = (ph_q >= div_i);
    ph_en    = clr_i | (run_i & src_tick);
    if (clr_i || terminal) ph_d = '0;
    else                   ph_d = ph_q + 1'b1;
    cnt_tick_o = run_i & src_tick & terminal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_d;
  end
endmodule

// File: rtl/cmt_compare.sv
module cmt_compare #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NCH   = 3
) (
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [NCH*CNT_W-1:0] cmp_flat_i,
  output logic [NCH-1:0]       hit_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign hit_o[g] = (cnt_i == cmp_flat_i[g*CNT_W +: CNT_W]);
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    at_max_o = &cnt_q;
    cnt_en   = clr_i | tick_i;
    if (clr_i || restart_i || at_max_o) cnt_d = '0;
    else                                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer import cmt_pkg::*; #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PSW   = 12
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             tick_fast_i,
  input  logic             tick_slow_i,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [IDX_W-1:0] bus_idx_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             irq_o
);
  logic                   rst_n;
  logic                   wr_any, wr_ctrl, wr_psc, wr_stat, wr_ien;
  logic [NCMP-1:0]        wr_cmp;
  logic [31:0]            idx_w;
  logic                   soft_rst, start_zero, cnt_clr, period_wrap;
  logic                   run_q, free_q, cnt_tick, at_max;
  logic [BUS_W-1:0]       ctrl_q, ctrl_d, ctrl_wval;
  logic [PSW-1:0]         psc_q, psc_d;
  logic [NFLAG-1:0]       sr_q, sr_d, ien_q, ien_d, set_v, clr_v;
  logic                   sr_en, psc_en, ien_en;
  logic [CNT_W-1:0]       cmp_q [NCMP];
  logic [NCMP*CNT_W-1:0]  cmp_flat;
  logic [BUS_W-1:0]       cap_q [NCAP];
  logic [CNT_W-1:0]       cnt_q;
  logic [NCMP-1:0]        hit;
  logic [BUS_W-1:0]       rd_mux;

  cmt_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n_o(rst_n));

  // ---------------- bus decode ----------------
  always_comb begin
    idx_w     = 32'(bus_idx_i);
    wr_any    = bus_sel_i & bus_we_i;
    wr_ctrl   = wr_any && (idx_w == IX_CTRL);
    wr_psc    = wr_any && (idx_w == IX_PSC);
    wr_stat   = wr_any && (idx_w == IX_STAT);
    wr_ien    = wr_any && (idx_w == IX_IEN);
    ctrl_wval = bus_wdata_i & ~(CTRL_FORCE0 | CTRL_SELFCLR);
    soft_rst  = wr_ctrl & bus_wdata_i[CB_SOFT];
  end

  assign run_q  = ctrl_q[CB_RUN];
  assign free_q = ctrl_q[CB_FREE];

  // ---------------- control register ----------------
  always_comb begin
    if (soft_rst) ctrl_d = ctrl_wval & ~CTRL_RSTCLR;
    else          ctrl_d = ctrl_wval;
    start_zero = wr_ctrl & ~soft_rst & ctrl_wval[CB_RUN] & ~run_q & ctrl_wval[CB_ZERO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  // ---------------- prescaler and interrupt enable ----------------
  always_comb begin
    psc_en = soft_rst | wr_psc;
    psc_d  = soft_rst ? '0 : bus_wdata_i[PSW-1:0];
    ien_en = soft_rst | wr_ien;
    ien_d  = soft_rst ? '0 : bus_wdata_i[NFLAG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      ien_q <= '0;
    end else begin
      if (psc_en) psc_q <= psc_d;
      if (ien_en) ien_q <= ien_d;
    end
  end

  // ---------------- compare and capture registers ----------------
  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    assign wr_cmp[g] = wr_any && (idx_w == IX_CMP1 + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cmp_q[g] <= '1;
      else if (soft_rst || wr_cmp[g]) cmp_q[g] <= soft_rst ? '1 : bus_wdata_i[CNT_W-1:0];
    end
    assign cmp_flat[g*CNT_W +: CNT_W] = cmp_q[g];
  end

  for (genvar g = 0; g < NCAP; g++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cap_q[g] <= '0;
      else if (soft_rst) cap_q[g] <= '0;
    end
  end

  // ---------------- count path ----------------
  cmt_tick_sel #(.PSW(PSW)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .src_i(ctrl_q[CB_SRC +: 3]),
    .tick_fast_i(tick_fast_i), .tick_slow_i(tick_slow_i), .div_i(psc_q),
    .clr_i(soft_rst), .cnt_tick_o(cnt_tick)
  );

  cmt_compare #(.CNT_W(CNT_W), .NCH(NCMP)) u_cmp (
    .cnt_i(cnt_q), .cmp_flat_i(cmp_flat), .hit_o(hit)
  );

  assign period_wrap = ~free_q & hit[0];
  assign cnt_clr     = soft_rst | start_zero | (wr_cmp[0] & ~free_q);

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(cnt_tick), .clr_i(cnt_clr),
    .restart_i(period_wrap), .cnt_o(cnt_q), .at_max_o(at_max)
  );

  // ---------------- status flags ----------------
  always_comb begin
    set_v = '0;
    if (cnt_tick) begin
      set_v[NCMP-1:0] = hit;
      set_v[FL_ROLL]  = at_max;
    end
    clr_v = wr_stat ? bus_wdata_i[NFLAG-1:0] : '0;
    sr_en = soft_rst | wr_stat | (|set_v);
    if (soft_rst) sr_d = '0;
    else          sr_d = (sr_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  // ---------------- read mux and interrupt ----------------
  always_comb begin
    rd_mux = '0;
    case (idx_w)
      IX_CTRL:      rd_mux = ctrl_q;
      IX_PSC:       rd_mux[PSW-1:0] = psc_q;
      IX_STAT:      rd_mux[NFLAG-1:0] = sr_q;
      IX_IEN:       rd_mux[NFLAG-1:0] = ien_q;
      IX_CMP1:      rd_mux[CNT_W-1:0] = cmp_q[0];
      IX_CMP1 + 1:  rd_mux[CNT_W-1:0] = cmp_q[1];
      IX_CMP1 + 2:  rd_mux[CNT_W-1:0] = cmp_q[2];
      IX_CAP1:      rd_mux = cap_q[0];
      IX_CAP1 + 1:  rd_mux = cap_q[1];
      IX_CNT:       rd_mux[CNT_W-1:0] = cnt_q;
      default:      rd_mux = '0;
    endcase
  end

  assign bus_rdata_o = (bus_sel_i & ~bus_we_i) ? rd_mux : '0;
  assign irq_o       = run_q & (|(sr_q & ien_q));
endmodule

// File: rtl/cmt_checker.sv
module cmt_checker import cmt_pkg::*; #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel_i,
  input logic             bus_we_i,
  input logic [IDX_W-1:0] bus_idx_i,
  input logic [BUS_W-1:0] bus_wdata_i,
  input logic             irq_i,
  input logic             run_i,
  input logic             free_i,
  input logic             soft_i,
  input logic             cnt_tick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmp1_i,
  input logic [NFLAG-1:0] sr_i,
  input logic [NFLAG-1:0] set_i
);
  logic wr_any, wr_stat;
  assign wr_any  = bus_sel_i & bus_we_i;
  assign wr_stat = wr_any && (32'(bus_idx_i) == IX_STAT);

  assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !irq_i);

  assert_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && set_i == '0) |=> ((sr_i & $past(bus_wdata_i[NFLAG-1:0])) == '0));

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0 && !soft_i) |=> ((sr_i & $past(set_i)) == $past(set_i)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_any) |=> $stable(cnt_i));

  assert_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick_i && !free_i && cnt_i == cmp1_i) |=> (cnt_i == '0));

  assert_rollover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick_i && (&cnt_i) && !soft_i) |=> sr_i[FL_ROLL]);

  assert_soft_R4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_i |=> (sr_i == '0 && cnt_i == '0));

  assert_no_capflag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_i[4:3] == 2'b00);
endmodule

bind cmp_timer cmt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
  .bus_idx_i(bus_idx_i), .bus_wdata_i(bus_wdata_i), .irq_i(irq_o),
  .run_i(run_q), .free_i(free_q), .soft_i(soft_rst), .cnt_tick_i(cnt_tick),
  .cnt_i(cnt_q), .cmp1_i(cmp_q[0]), .sr_i(sr_q), .set_i(set_v)
);

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
  localparam int CLK_P = 10;
  localparam int NV    = 32;

  // vector: {req[3:0], write, idx[3:0], data[31:0], expect[31:0]}
  localparam logic [72:0] VEC [NV] = '{
    {4'd2,  1'b0, 4'h0, 32'h0,        32'h0},          // R2 reset values
    {4'd2,  1'b0, 4'h1, 32'h0,        32'h0},
    {4'd2,  1'b0, 4'h2, 32'h0,        32'h0},
    {4'd2,  1'b0, 4'h3, 32'h0,        32'h0},
    {4'd2,  1'b0, 4'h4, 32'h0,        32'hFFFF_FFFF},
    {4'd2,  1'b0, 4'h5, 32'h0,        32'hFFFF_FFFF},
    {4'd2,  1'b0, 4'h6, 32'h0,        32'hFFFF_FFFF},
    {4'd2,  1'b0, 4'h7, 32'h0,        32'h0},
    {4'd2,  1'b0, 4'h8, 32'h0,        32'h0},
    {4'd2,  1'b0, 4'h9, 32'h0,        32'h0},
    {4'd1,  1'b0, 4'hD, 32'h0,        32'h0},          // R1 unmapped read
    {4'd3,  1'b1, 4'h0, 32'hABCD_7FFF, 32'h0},         // R3 control mask
    {4'd3,  1'b0, 4'h0, 32'h0,        32'hABCD_03EB},
    {4'd13, 1'b1, 4'h1, 32'hFFFF_FFFF, 32'h0},         // R13 widths
    {4'd13, 1'b0, 4'h1, 32'h0,        32'h0000_0FFF},
    {4'd13, 1'b1, 4'h3, 32'hFFFF_FFFF, 32'h0},
    {4'd13, 1'b0, 4'h3, 32'h0,        32'h0000_003F},
    {4'd1,  1'b1, 4'h5, 32'h1234_5678, 32'h0},         // R1 map
    {4'd1,  1'b0, 4'h5, 32'h0,        32'h1234_5678},
    {4'd1,  1'b1, 4'h9, 32'h0000_0055, 32'h0},
    {4'd1,  1'b0, 4'h9, 32'h0,        32'h0},
    {4'd1,  1'b1, 4'h7, 32'h0000_AAAA, 32'h0},
    {4'd1,  1'b0, 4'h7, 32'h0,        32'h0},
    {4'd1,  1'b1, 4'hC, 32'h0000_0005, 32'h0},
    {4'd1,  1'b0, 4'hC, 32'h0,        32'h0},
    {4'd1,  1'b0, 4'h5, 32'h0,        32'h1234_5678},
    {4'd4,  1'b1, 4'h0, 32'hABCD_83EB, 32'h0},         // R4 soft reset
    {4'd4,  1'b0, 4'h0, 32'h0,        32'hABCD_03C0},
    {4'd4,  1'b0, 4'h1, 32'h0,        32'h0},
    {4'd4,  1'b0, 4'h3, 32'h0,        32'h0},
    {4'd4,  1'b0, 4'h5, 32'h0,        32'hFFFF_FFFF},
    {4'd4,  1'b0, 4'h2, 32'h0,        32'h0}
  };

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        arst_n, tick_fast, tick_slow;
  logic [2:0]  slow_ctr;
  logic        sel0, we0, sel1, we1;
  logic [3:0]  idx0, idx1;
  logic [31:0] wd0, wd1, rd0, rd1;
  logic        irq0, irq1;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  cmp_timer u0 (
    .clk(clk), .arst_n(arst_n), .tick_fast_i(tick_fast), .tick_slow_i(tick_slow),
    .bus_sel_i(sel0), .bus_we_i(we0), .bus_idx_i(idx0), .bus_wdata_i(wd0),
    .bus_rdata_o(rd0), .irq_o(irq0)
  );

  cmp_timer #(.CNT_W(8)) u1 (
    .clk(clk), .arst_n(arst_n), .tick_fast_i(tick_fast), .tick_slow_i(tick_slow),
    .bus_sel_i(sel1), .bus_we_i(we1), .bus_idx_i(idx1), .bus_wdata_i(wd1),
    .bus_rdata_o(rd1), .irq_o(irq1)
  );

  // slow tick: one cycle in eight, changed away from the active edge
  always @(negedge clk) begin
    if (!arst_n) slow_ctr <= 3'd1;
    else         slow_ctr <= slow_ctr + 3'd1;
  end
  assign tick_slow = arst_n && (slow_ctr == 3'd0);

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp,
                     input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // both tasks start and end at a falling edge
  task automatic bwr(input bit u, input logic [3:0] ix, input logic [31:0] d);
    if (u) begin sel1 = 1'b1; we1 = 1'b1; idx1 = ix; wd1 = d; end
    else   begin sel0 = 1'b1; we0 = 1'b1; idx0 = ix; wd0 = d; end
    @(negedge clk);
    sel0 = 1'b0; we0 = 1'b0; sel1 = 1'b0; we1 = 1'b0;
  endtask

  task automatic brd(input bit u, input logic [3:0] ix, output logic [31:0] d);
    if (u) begin sel1 = 1'b1; we1 = 1'b0; idx1 = ix; end
    else   begin sel0 = 1'b1; we0 = 1'b0; idx0 = ix; end
    #1;
    d = u ? rd1 : rd0;
    @(negedge clk);
    sel0 = 1'b0; sel1 = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, mx;
    arst_n = 1'b0; tick_fast = 1'b0;
    sel0 = 0; we0 = 0; idx0 = 0; wd0 = 0;
    sel1 = 0; we1 = 0; idx1 = 0; wd1 = 0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(2, {31'b0, irq0}, 32'h0, "irq after reset"); // R2
    tick_fast = 1'b1;

    // table walk: register map, masks, soft reset
    for (int i = 0; i < NV; i++) begin
      automatic logic [72:0] v = VEC[i];
      if (v[68]) bwr(1'b0, v[67:64], v[63:32]);
      else begin
        brd(1'b0, v[67:64], a);
        chk(int'(v[72:69]), a, v[31:0], $sformatf("table entry %0d", i));
      end
    end

    // free-run counting, compare flags, interrupt (R5 R7 R11 R12)
    bwr(0, 4'h4, 32'd5);
    bwr(0, 4'h5, 32'd6);
    bwr(0, 4'h3, 32'h1);
    bwr(0, 4'h0, 32'h0000_0241);
    brd(0, 4'h9, a);
    brd(0, 4'h9, b);
    chk(5, b, a + 32'd1, "fast tick divide by 1");            // R5
    repeat (10) @(negedge clk);
    brd(0, 4'h2, a);
    chk(7, a, 32'h3, "compare 1 and 2 flags");                // R7
    chk(12, {31'b0, irq0}, 32'h1, "irq with flag enabled");   // R12
    bwr(0, 4'h2, 32'h1);
    brd(0, 4'h2, a);
    chk(11, a, 32'h2, "write one clears only that flag");     // R11
    chk(12, {31'b0, irq0}, 32'h0, "irq after clear");          // R12
    bwr(0, 4'h3, 32'h2);
    chk(12, {31'b0, irq0}, 32'h1, "irq on enable of pending"); // R12
    bwr(0, 4'h0, 32'h0000_0240);
    chk(12, {31'b0, irq0}, 32'h0, "irq gated by run");         // R12
    brd(0, 4'h9, a);
    repeat (5) @(negedge clk);
    brd(0, 4'h9, b);
    chk(6, b, a, "counter holds while stopped");              // R6

    // prescaler and zero-on-start (R5 R6)
    bwr(0, 4'h1, 32'd3);
    bwr(0, 4'h0, 32'h0000_0243);
    brd(0, 4'h9, a);
    chk(6, a, 32'h0, "zero on start");                        // R6
    brd(0, 4'h9, a);
    repeat (15) @(negedge clk);
    brd(0, 4'h9, b);
    chk(5, b - a, 32'd4, "prescaler 3 over 16 ticks");        // R5

    // no-clock code, then slow source (R5)
    bwr(0, 4'h0, 32'h0000_02C1);
    brd(0, 4'h9, a);
    repeat (9) @(negedge clk);
    brd(0, 4'h9, b);
    chk(5, b, a, "source code 011 gives no count");           // R5
    bwr(0, 4'h1, 32'd0);
    bwr(0, 4'h0, 32'h0000_0301);
    brd(0, 4'h9, a);
    repeat (31) @(negedge clk);
    brd(0, 4'h9, b);
    chk(5, b - a, 32'd4, "slow tick over 32 cycles");         // R5

    // restart mode (R9 R10)
    bwr(0, 4'h0, 32'h0000_0041);
    bwr(0, 4'h4, 32'd4);
    brd(0, 4'h9, a);
    chk(10, a, 32'h0, "compare 1 write zeroes count");        // R10
    repeat (6) @(negedge clk);
    brd(0, 4'h9, b);
    chk(9, b, 32'd2, "count after 7 ticks with period 5");    // R9
    mx = 0;
    for (int k = 0; k < 12; k++) begin
      brd(0, 4'h9, a);
      if (a > mx) mx = a;
    end
    chk(9, mx, 32'd4, "peak count equals compare 1");         // R9
    brd(0, 4'h2, a);
    chk(7, a & 32'h1, 32'h1, "compare 1 flag in restart");    // R7

    // rollover on the 8-bit instance (R8)
    bwr(1, 4'h3, 32'h20);
    bwr(1, 4'h0, 32'h0000_0241);
    repeat (100) @(negedge clk);
    brd(1, 4'h2, a);
    chk(8, a & 32'h20, 32'h0, "no rollover before top");      // R8
    repeat (200) @(negedge clk);
    brd(1, 4'h2, a);
    chk(8, a & 32'h20, 32'h20, "rollover flag set");          // R8
    chk(12, {31'b0, irq1}, 32'h1, "irq from rollover");        // R12
    brd(1, 4'h9, a);
    chk(8, {31'b0, (a < 32'd100)}, 32'h1, "count wrapped to low value"); // R8

    done = 1'b1;
    summary();
    $finish;
  end
endmodule